// File: doc/BRIEF.md
# In-Order Write Issue Queue

This block sits between the read side and the write side of a transfer engine. Transfer requests are accepted one at a time into a single-entry program stage, then moved into a small circular queue, where each one waits for its write phase. When a request enters the queue, the block reports the entry index assigned to it. That index is the tag the read side uses to signal that the request's data has arrived.

Read completions may come back in any order. Each one marks its entry as done. Write commands, however, leave strictly in acceptance order: only the oldest entry can issue, and only once its data is done. Issuing removes that entry.

For debug, the block exposes the head index, the number of occupied entries, a flag for pending read activity, a flag for an occupied program stage, and a sticky flag for completions that name an empty entry.

Top module: `tr_write_order_queue`

## Requirements
- R1: The DEPTH parameter must be 2 or 4. Entry indices and tags are PTR_W = log2(DEPTH) bits wide. After reset the block shows count 0, head 0, `push_ready_o` high, and all other flags and `wr_valid_o` low.
- R2: A push accepted at a clock edge occupies the program stage, so `prog_busy_o` is high in the next cycle. If the queue is not full, the request enters the queue at the following edge. During that cycle `alloc_valid_o` is high and `alloc_tag_o` equals (head + count) mod DEPTH.
- R3: While the program stage is occupied and the count equals DEPTH, `push_ready_o` is low, and the held request does not enter the queue.
- R4: A completion whose tag names an occupied entry marks that entry done, whatever order completions arrive in.
- R5: `wr_valid_o` is high exactly when the head entry is occupied and done. `wr_id_o` and `wr_tag_o` then give that entry's request id and index, so ids leave in acceptance order.
- R6: Each issued write advances the head by one modulo DEPTH and lowers the count by one. An issue and an enqueue at the same edge leave the count unchanged.
- R7: The count never exceeds DEPTH.
- R8: `src_active_o` is high exactly when some occupied entry is not yet done.
- R9: A completion for an unoccupied tag changes no entry, no count and no output other than `proto_err_o`. `proto_err_o` rises and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_valid_i | input | 1 | Request offered |
| push_id_i | input | ID_W | Request id |
| push_ready_o | output | 1 | Program stage can take a request |
| alloc_valid_o | output | 1 | Held request enters the queue this cycle |
| alloc_tag_o | output | PTR_W | Entry index assigned to it |
| cpl_valid_i | input | 1 | Read data complete |
| cpl_tag_i | input | PTR_W | Entry index of the completion |
| wr_valid_o | output | 1 | Write command issued this cycle |
| wr_id_o | output | ID_W | Id of the issued request |
| wr_tag_o | output | PTR_W | Entry index of the issued request |
| head_ptr_o | output | PTR_W | Index of the oldest entry |
| count_o | output | CNT_W | Occupied entries |
| src_active_o | output | 1 | Some entry awaits read data |
| prog_busy_o | output | 1 | Program stage occupied |
| proto_err_o | output | 1 | Sticky stray-completion flag |

## Verification
Four-request rounds are completed in all 24 orders of their tags. Rounds are interleaved with single-request rounds, so the head sits at every index and pending entries wrap past the last index. This separates true in-order issue from issue-when-done, and correct modulo wrap from linear indexing. A back-to-back fill shows the program stage holding a fifth request against a full queue and then releasing it as the head drains. A staged cycle with an issue and an enqueue together separates a held count from a double update. A stray completion on an empty queue checks that the error flag is sticky and that nothing else changes.

// File: rtl/wq_pkg.sv
package wq_pkg;
  typedef enum logic [1:0] {CPL_IDLE, CPL_HIT, CPL_MISS} cpl_kind_e;

  function automatic int unsigned cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/wq_prog_stage.sv
module wq_prog_stage #(
  parameter int unsigned ID_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_valid_i,
  input  logic [ID_W-1:0] push_id_i,
  output logic            push_ready_o,
  input  logic            q_full_i,
  output logic            enq_o,
  output logic [ID_W-1:0] enq_id_o,
  output logic            busy_o
);
  logic            busy_q;
  logic [ID_W-1:0] id_q;
  logic            accept;

  assign enq_o        = busy_q && !q_full_i;
  assign push_ready_o = !busy_q || enq_o;
  assign accept       = push_valid_i && push_ready_o;
  assign enq_id_o     = id_q;
  assign busy_o       = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      id_q   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      id_q   <= push_id_i;
    end else if (enq_o) begin
      busy_q <= 1'b0;
    end
  end

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_q && id_q == $past(push_id_i));

  assert_prog_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && q_full_i && !push_valid_i |=> busy_q && $stable(id_q));
endmodule

// File: rtl/wq_ptr_ctrl.sv
module wq_ptr_ctrl #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PTR_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [PTR_W-1:0] head_q;
  logic [CNT_W-1:0] count_q;

  // depth is a power of two, so truncation is the modulo
  assign tail_o  = head_q + count_q[PTR_W-1:0];
  assign head_o  = head_q;
  assign count_o = count_q;
  assign full_o  = (count_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      if (pop_i) head_q <= head_q + 1'b1;
      unique case ({enq_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_MAX);

  assert_no_enq_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_i |-> count_q != CNT_MAX);

  assert_no_pop_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count_q != '0);

  assert_head_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> head_q == PTR_W'($past(head_q) + 1'b1));

  assert_count_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_i && pop_i |=> $stable(count_q));
endmodule

// File: rtl/wq_entry_array.sv
module wq_entry_array
  import wq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned ID_W  = 8,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_i,
  input  logic [PTR_W-1:0] enq_idx_i,
  input  logic [ID_W-1:0]  enq_id_i,
  input  logic             cpl_valid_i,
  input  logic [PTR_W-1:0] cpl_tag_i,
  input  logic [PTR_W-1:0] head_i,
  output logic             pop_o,
  output logic [ID_W-1:0]  head_id_o,
  output logic             src_active_o,
  output logic             miss_o
);
  logic [DEPTH-1:0] valid_vec;
  logic [DEPTH-1:0] done_vec;
  logic [ID_W-1:0]  ids [DEPTH];
  cpl_kind_e        cpl_kind;

  always_comb begin
    if (!cpl_valid_i)              cpl_kind = CPL_IDLE;
    else if (valid_vec[cpl_tag_i]) cpl_kind = CPL_HIT;
    else                           cpl_kind = CPL_MISS;
  end

  assign pop_o        = valid_vec[head_i] && done_vec[head_i];
  assign head_id_o    = ids[head_i];
  assign src_active_o = |(valid_vec & ~done_vec);
  assign miss_o       = (cpl_kind == CPL_MISS);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic            v_q;
    logic            d_q;
    logic [ID_W-1:0] id_q;
    logic            set_w, clr_w, hit_w;

    assign set_w = enq_i && (enq_idx_i == PTR_W'(i));
    assign clr_w = pop_o && (head_i == PTR_W'(i));
    assign hit_w = (cpl_kind == CPL_HIT) && (cpl_tag_i == PTR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q  <= 1'b0;
        d_q  <= 1'b0;
        id_q <= '0;
      end else if (set_w) begin
        v_q  <= 1'b1;
        d_q  <= 1'b0;
        id_q <= enq_id_i;
      end else begin
        if (clr_w) v_q <= 1'b0;
        if (hit_w) d_q <= 1'b1;
      end
    end

    assign valid_vec[i] = v_q;
    assign done_vec[i]  = d_q;
    assign ids[i]       = id_q;
  end

  assert_cpl_marks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_i && valid_vec[cpl_tag_i] |=> done_vec[$past(cpl_tag_i)]);

  assert_enq_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_i |-> !valid_vec[enq_idx_i]);

  assert_pop_frees_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o && !(enq_i && enq_idx_i == head_i) |=> !valid_vec[$past(head_i)]);

  assert_miss_inert_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_i && !valid_vec[cpl_tag_i] && !enq_i && !pop_o |=> $stable(valid_vec) && $stable(done_vec));
endmodule

// File: rtl/tr_write_order_queue.sv
module tr_write_order_queue
  import wq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned ID_W  = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = cnt_width(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_valid_i,
  input  logic [ID_W-1:0]  push_id_i,
  output logic             push_ready_o,
  output logic             alloc_valid_o,
  output logic [PTR_W-1:0] alloc_tag_o,
  input  logic             cpl_valid_i,
  input  logic [PTR_W-1:0] cpl_tag_i,
  output logic             wr_valid_o,
  output logic [ID_W-1:0]  wr_id_o,
  output logic [PTR_W-1:0] wr_tag_o,
  output logic [PTR_W-1:0] head_ptr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             src_active_o,
  output logic             prog_busy_o,
  output logic             proto_err_o
);
  initial begin
    assert_depth_R1: assert (DEPTH == 2 || DEPTH == 4)
      else $error("DEPTH must be 2 or 4");
  end

  logic            enq, pop, full, miss, err_q;
  logic [ID_W-1:0] enq_id;
  logic [PTR_W-1:0] head, tail;

  wq_prog_stage #(.ID_W(ID_W)) u_prog (
    .clk_i, .rst_ni,
    .push_valid_i, .push_id_i, .push_ready_o,
    .q_full_i (full),
    .enq_o    (enq),
    .enq_id_o (enq_id),
    .busy_o   (prog_busy_o)
  );

  wq_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
    .clk_i, .rst_ni,
    .enq_i   (enq),
    .pop_i   (pop),
    .head_o  (head),
    .tail_o  (tail),
    .count_o (count_o),
    .full_o  (full)
  );

  wq_entry_array #(.DEPTH(DEPTH), .ID_W(ID_W), .PTR_W(PTR_W)) u_ent (
    .clk_i, .rst_ni,
    .enq_i        (enq),
    .enq_idx_i    (tail),
    .enq_id_i     (enq_id),
    .cpl_valid_i, .cpl_tag_i,
    .head_i       (head),
    .pop_o        (pop),
    .head_id_o    (wr_id_o),
    .src_active_o (src_active_o),
    .miss_o       (miss)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   err_q <= 1'b0;
    else if (miss) err_q <= 1'b1;
  end

  assign alloc_valid_o = enq;
  assign alloc_tag_o   = tail;
  assign wr_valid_o    = pop;
  assign wr_tag_o      = head;
  assign head_ptr_o    = head;
  assign proto_err_o   = err_q;

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  assert_err_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(cpl_valid_i));

  assert_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_ready_o |-> prog_busy_o && count_o == CNT_W'(DEPTH));
endmodule

// File: tb/tb_tr_write_order_queue.sv
`timescale 1ns/1ps
module tb_tr_write_order_queue;
  localparam int DEPTH = 4;
  localparam int ID_W  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 1'b0;
  logic [7:0] push_id = '0;
  logic       push_ready, alloc_valid;
  logic [1:0] alloc_tag;
  logic       cpl_valid = 1'b0;
  logic [1:0] cpl_tag = '0;
  logic       wr_valid;
  logic [7:0] wr_id;
  logic [1:0] wr_tag, head_ptr;
  logic [2:0] count;
  logic       src_active, prog_busy, proto_err;

  always #2.5 clk = ~clk;

  tr_write_order_queue #(.DEPTH(DEPTH), .ID_W(ID_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .push_valid_i(push_valid), .push_id_i(push_id), .push_ready_o(push_ready),
    .alloc_valid_o(alloc_valid), .alloc_tag_o(alloc_tag),
    .cpl_valid_i(cpl_valid), .cpl_tag_i(cpl_tag),
    .wr_valid_o(wr_valid), .wr_id_o(wr_id), .wr_tag_o(wr_tag),
    .head_ptr_o(head_ptr), .count_o(count),
    .src_active_o(src_active), .prog_busy_o(prog_busy), .proto_err_o(proto_err)
  );

  int nvec = 0, nfail = 0;
  int mh = 0, mc = 0;
  logic [7:0] id_at [DEPTH];
  bit mdone [DEPTH];
  logic [7:0] next_id = 8'h10;

  task automatic chk(input string req, input longint act, input longint exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_src_active();
    for (int k = 0; k < mc; k++) if (!mdone[(mh + k) % DEPTH]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic push_one(output int tag);
    @(negedge clk); push_valid = 1'b1; push_id = next_id; #1;
    chk("R2 ready", push_ready, 1);
    @(posedge clk);
    @(negedge clk); push_valid = 1'b0; #1;
    chk("R2 prog_busy", prog_busy, 1);
    chk("R2 alloc_valid", alloc_valid, 1);
    chk("R2 alloc_tag", alloc_tag, (mh + mc) % DEPTH);
    tag = int'(alloc_tag);
    id_at[tag] = next_id; mdone[tag] = 1'b0;
    next_id++;
    @(posedge clk); mc++;
    @(negedge clk); #1;
    chk("R2 count", count, mc);
    chk("R2 prog idle", prog_busy, 0);
    chk("R8 src_active", src_active, exp_src_active());
  endtask

  task automatic drain();
    while (mc > 0 && mdone[mh]) begin
      chk("R5 wr_valid", wr_valid, 1);
      chk("R5 wr_id", wr_id, id_at[mh]);
      chk("R5 wr_tag", wr_tag, mh);
      @(posedge clk); mh = (mh + 1) % DEPTH; mc--;
      @(negedge clk); #1;
    end
    chk("R5 no issue", wr_valid, 0);
    chk("R6 count", count, mc);
    chk("R6 head", head_ptr, mh);
    chk("R8 src_active", src_active, exp_src_active());
  endtask

  task automatic complete(input int tag);
    @(negedge clk); cpl_valid = 1'b1; cpl_tag = 2'(tag);
    @(posedge clk);
    @(negedge clk); cpl_valid = 1'b0; mdone[tag] = 1'b1; #1;
    drain();
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int t4 [4];
    int tg, pi;
    logic [7:0] seen [8];
    int ns, t5;
    bit pend;
    #12; #1;
    chk("R1 count", count, 0);
    chk("R1 head", head_ptr, 0);
    chk("R1 ready", push_ready, 1);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 flags", {src_active, prog_busy, proto_err, alloc_valid}, 0);
    rst_n = 1'b1;

    // R4 R5: every completion order of four tags, head shifted by single rounds
    pi = 0;
    for (int code = 0; code < 256; code++) begin
      int d [4];
      bit ok;
      ok = 1'b1;
      for (int j = 0; j < 4; j++) d[j] = (code >> (2 * j)) & 3;
      for (int a = 0; a < 4; a++)
        for (int b = a + 1; b < 4; b++) if (d[a] == d[b]) ok = 1'b0;
      if (ok) begin
        if (pi % 2 == 1) begin
          push_one(tg);
          complete(tg);
        end
        for (int j = 0; j < 4; j++) push_one(t4[j]);
        chk("R7 full count", count, DEPTH);
        for (int j = 0; j < 4; j++) complete(t4[d[j]]);
        pi++;
      end
    end
    chk("R4 perms", pi, 24);

    // R3: back-to-back fill, fifth request held in program stage
    for (int n = 0; n < 5; n++) begin
      @(negedge clk); push_valid = 1'b1; push_id = 8'hA0 + 8'(n); #1;
      chk("R3 ready before full", push_ready, 1);
      @(posedge clk);
    end
    @(negedge clk); push_id = 8'hA5; #1;
    chk("R3 refuse", push_ready, 0);
    chk("R7 count", count, DEPTH);
    chk("R3 prog held", prog_busy, 1);
    @(posedge clk);
    @(negedge clk); push_valid = 1'b0; #1;
    chk("R3 still refused", push_ready, 0);
    chk("R3 no enq", alloc_valid, 0);
    ns = 0; pend = 1'b0; t5 = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk); cpl_valid = 1'b0;
      if (c < 4) begin
        cpl_valid = 1'b1; cpl_tag = 2'((mh + 3 - c) % DEPTH);
      end else if (pend) begin
        cpl_valid = 1'b1; cpl_tag = 2'(t5); pend = 1'b0;
      end
      #1;
      if (alloc_valid) begin t5 = int'(alloc_tag); pend = 1'b1; end
      if (wr_valid && ns < 8) begin seen[ns] = wr_id; ns++; end
      @(posedge clk);
    end
    @(negedge clk); cpl_valid = 1'b0; #1;
    chk("R5 issue count", ns, 5);
    for (int k = 0; k < 5; k++) chk("R5 order", seen[k], 8'hA0 + k);
    chk("R9 no false error", proto_err, 0);
    mh = (mh + 5) % DEPTH; mc = 0;
    chk("R6 head after fill", head_ptr, mh);
    chk("R6 empty", count, 0);

    // R6: issue and enqueue at the same edge
    @(negedge clk); push_valid = 1'b1; push_id = 8'hC0;
    @(posedge clk);
    @(negedge clk); push_valid = 1'b0; #1;
    tg = int'(alloc_tag);
    chk("R2 tag", tg, mh);
    @(posedge clk);
    @(negedge clk); cpl_valid = 1'b1; cpl_tag = 2'(tg); push_valid = 1'b1; push_id = 8'hC1;
    @(posedge clk);
    @(negedge clk); cpl_valid = 1'b0; push_valid = 1'b0; #1;
    chk("R5 issue", wr_valid, 1);
    chk("R5 id", wr_id, 8'hC0);
    chk("R6 enq same cycle", alloc_valid, 1);
    chk("R6 count before", count, 1);
    @(posedge clk);
    @(negedge clk); #1;
    chk("R6 count held", count, 1);
    chk("R6 head step", head_ptr, (mh + 1) % DEPTH);
    chk("R8 pending", src_active, 1);
    mh = (mh + 1) % DEPTH; mc = 1; id_at[mh] = 8'hC1; mdone[mh] = 1'b0;
    complete(mh);

    // R9: stray completion on an empty queue
    @(negedge clk); cpl_valid = 1'b1; cpl_tag = 2'((mh + 2) % DEPTH);
    @(posedge clk);
    @(negedge clk); cpl_valid = 1'b0; #1;
    chk("R9 err", proto_err, 1);
    chk("R9 count", count, 0);
    chk("R9 no issue", wr_valid, 0);
    chk("R9 head", head_ptr, mh);
    chk("R9 src idle", src_active, 0);
    push_one(tg);
    chk("R9 not marked done", wr_valid, 0);
    complete(tg);
    chk("R9 sticky", proto_err, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule